// File: doc/BRIEF.md
# Narrow-Datapath Single-Cycle Processor Core

This block is a single-cycle processor for a small load/store instruction subset. Instructions are full 32-bit words in the usual three-format layout. The register file, ALU, data memory and program counter are only 8 bits wide, and immediates are taken from the low byte of the instruction with no sign extension. In each clock the core fetches the word at the current program counter, decodes it, reads two registers, runs the ALU, optionally reads or writes the data memory and writes the result back. It then advances the program counter to the sequential, branch or jump target.

Programs are placed in the instruction memory through a dedicated write port, normally while reset is held. After reset is released, execution starts at address 0. The program counter, the instruction being executed and the ALU output are exposed on ports, so the core can be observed from outside.

Top module: `mini_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 and every register k is loaded with the value k (register 0 holds 0).
- R2: Each cycle `instr_o` shows the instruction-memory word at index `pc_o[7:2]`. For any opcode other than beq (000100), bne (000101) and j (000010), the next `pc_o` is `pc_o + 4` modulo 256.
- R3: For opcode 000000, the field bits 31:26 opcode, 25:21 rs, 20:16 rt, 15:11 rd and 5:0 funct select the operation: add 0x20, sub 0x22, and 0x24, or 0x25, slt 0x2A. rd receives the 8-bit result, which is also shown on `alu_o`. slt yields 1 when rs < rt as signed 8-bit values and 0 otherwise.
- R4: Register 0 always reads as 0, and writes addressed to it are dropped.
- R5: addi (001000) writes rs + instr[7:0] into rt, modulo 256. Bits 15:8 of the immediate are ignored.
- R6: lw (100011) and sw (101011) use the address rs + instr[7:0], which is shown on `alu_o`. The low 5 bits of that address select one of 32 data bytes. lw writes the byte to rt, and sw stores rt.
- R7: beq shows rs − rt on `alu_o`. When that result is zero, the next PC is (PC + 4) + (instr[7:0] << 2), truncated to 8 bits; otherwise it is PC + 4.
- R8: bne takes the same target as beq, but only when rs − rt is non-zero.
- R9: j sets the next PC to {instr[5:0], 2'b00}. Instruction bits 25:6 have no effect.
- R10: An unsupported opcode, or an opcode-000000 word with an unsupported funct, writes neither a register nor the data memory, and the PC advances by 4.
- R11: When `imem_we` is high at a rising edge, `imem_wdata` is stored at word index `imem_waddr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_we | input | 1 | Instruction-memory write enable |
| imem_waddr | input | 6 | Instruction-memory word index |
| imem_wdata | input | 32 | Instruction word to store |
| pc_o | output | 8 | Current program counter |
| instr_o | output | 32 | Instruction being executed |
| alu_o | output | 8 | ALU result of the current instruction |

## Verification
The program-counter assertions assume the instruction memory is not rewritten at the word being executed while the core runs. The bench therefore fills every word through the write port only while reset is held. It drives all inputs at the falling edge, well away from the sampling edge. The stored programs keep every load address on a byte that a previous store in the same program has written, so no load returns an uninitialised value. Their backward branches always terminate, so the PC trace stays finite and matches the expected table entry by entry.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int XLEN   = 8;
    localparam int ILEN   = 32;
    localparam int REG_AW = 5;

    typedef logic [XLEN-1:0] word_t;
    typedef logic [ILEN-1:0] instr_t;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_J     = 6'h02;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_BNE   = 6'h05;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [1:0] {
        CLS_ADD   = 2'b00,
        CLS_SUB   = 2'b01,
        CLS_FUNCT = 2'b10
    } alu_class_e;

    typedef enum logic [2:0] {
        FN_DO_ADD,
        FN_DO_SUB,
        FN_DO_AND,
        FN_DO_OR,
        FN_DO_SLT
    } alu_fn_e;

    typedef struct packed {
        logic [5:0]      opcode;
        logic [4:0]      rs;
        logic [4:0]      rt;
        logic [4:0]      rd;
        logic [4:0]      shamt;
        logic [5:0]      funct;
    } ifields_t;

    typedef struct packed {
        logic       reg_dst;
        logic       jump;
        logic       branch;
        logic       branch_ne;
        logic       mem_read;
        logic       mem_to_reg;
        alu_class_e alu_class;
        logic       mem_write;
        logic       alu_src;
        logic       reg_write;
    } ctrl_t;

    function automatic logic funct_known(input logic [5:0] f);
        return (f == FN_ADD) || (f == FN_SUB) || (f == FN_AND) ||
               (f == FN_OR)  || (f == FN_SLT);
    endfunction

    function automatic alu_fn_e funct_to_fn(input logic [5:0] f);
        case (f)
            FN_SUB:  return FN_DO_SUB;
            FN_AND:  return FN_DO_AND;
            FN_OR:   return FN_DO_OR;
            FN_SLT:  return FN_DO_SLT;
            default: return FN_DO_ADD;
        endcase
    endfunction

    function automatic word_t alu_eval(input alu_fn_e fn, input word_t a, input word_t b);
        case (fn)
            FN_DO_SUB: return a - b;
            FN_DO_AND: return a & b;
            FN_DO_OR:  return a | b;
            FN_DO_SLT: return {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            default:   return a + b;
        endcase
    endfunction

endpackage

// File: rtl/mc_decoder.sv
module mc_decoder
    import mc_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = '0;
        ctrl.alu_class = CLS_ADD;
        case (opcode)
            OP_RTYPE: begin
                ctrl.reg_dst   = 1'b1;
                ctrl.alu_class = CLS_FUNCT;
                ctrl.reg_write = 1'b1;
            end
            OP_LW: begin
                ctrl.alu_src    = 1'b1;
                ctrl.mem_read   = 1'b1;
                ctrl.mem_to_reg = 1'b1;
                ctrl.reg_write  = 1'b1;
            end
            OP_SW: begin
                ctrl.alu_src   = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            OP_BEQ: begin
                ctrl.branch    = 1'b1;
                ctrl.alu_class = CLS_SUB;
            end
            OP_BNE: begin
                ctrl.branch_ne = 1'b1;
                ctrl.alu_class = CLS_SUB;
            end
            OP_ADDI: begin
                ctrl.alu_src   = 1'b1;
                ctrl.reg_write = 1'b1;
            end
            OP_J: begin
                ctrl.jump = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int W  = 8,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    localparam int N = 1 << AW;

    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs[i] <= W'(i);
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
(
    input  alu_class_e alu_class,
    input  logic [5:0] funct,
    input  word_t      a,
    input  word_t      b,
    output word_t      result,
    output logic       zero
);
    alu_fn_e fn;

    always_comb begin
        case (alu_class)
            CLS_SUB:   fn = FN_DO_SUB;
            CLS_FUNCT: fn = funct_to_fn(funct);
            default:   fn = FN_DO_ADD;
        endcase
    end

    assign result = alu_eval(fn, a, b);
    assign zero   = (result == '0);
endmodule

// File: rtl/mini_core.sv
module mini_core
    import mc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_BYTES = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          imem_we,
    input  logic [$clog2(IMEM_WORDS)-1:0] imem_waddr,
    input  logic [ILEN-1:0]               imem_wdata,
    output logic [XLEN-1:0]               pc_o,
    output logic [ILEN-1:0]               instr_o,
    output logic [XLEN-1:0]               alu_o
);
    localparam int IMEM_AW = $clog2(IMEM_WORDS);
    localparam int DMEM_AW = $clog2(DMEM_BYTES);

    instr_t   imem [IMEM_WORDS];
    word_t    dmem [DMEM_BYTES];

    word_t    pc_q, pc_next, pc_plus4, br_tgt, jmp_tgt;
    instr_t   instr;
    ifields_t f;
    ctrl_t    ctrl;
    word_t    imm, rs_val, rt_val, alu_b, alu_res, wb_val, dmem_rd;
    logic     zero, take_br, rf_we;
    logic [REG_AW-1:0]  wa;
    logic [DMEM_AW-1:0] daddr;

    always_ff @(posedge clk) begin
        if (imem_we) imem[imem_waddr] <= imem_wdata;
    end

    assign instr = imem[pc_q[IMEM_AW+1:2]];
    assign f     = ifields_t'(instr);
    assign imm   = instr[XLEN-1:0];

    mc_decoder u_dec (
        .opcode (f.opcode),
        .ctrl   (ctrl)
    );

    assign wa    = ctrl.reg_dst ? f.rd : f.rt;
    assign rf_we = ctrl.reg_write && ((f.opcode != OP_RTYPE) || funct_known(f.funct));

    mc_regfile #(.W(XLEN), .AW(REG_AW)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (f.rs),
        .ra2 (f.rt),
        .rd1 (rs_val),
        .rd2 (rt_val),
        .we  (rf_we),
        .wa  (wa),
        .wd  (wb_val)
    );

    assign alu_b = ctrl.alu_src ? imm : rt_val;

    mc_alu u_alu (
        .alu_class (ctrl.alu_class),
        .funct     (f.funct),
        .a         (rs_val),
        .b         (alu_b),
        .result    (alu_res),
        .zero      (zero)
    );

    assign daddr   = alu_res[DMEM_AW-1:0];
    assign dmem_rd = dmem[daddr];

    always_ff @(posedge clk) begin
        if (!rst && ctrl.mem_write) dmem[daddr] <= rt_val;
    end

    assign wb_val = (ctrl.mem_to_reg && ctrl.mem_read) ? dmem_rd : alu_res;

    assign pc_plus4 = pc_q + XLEN'(4);
    assign br_tgt   = pc_plus4 + {imm[XLEN-3:0], 2'b00};
    assign jmp_tgt  = {instr[XLEN-3:0], 2'b00};
    assign take_br  = (ctrl.branch && zero) || (ctrl.branch_ne && !zero);

    always_comb begin
        if (ctrl.jump)   pc_next = jmp_tgt;
        else if (take_br) pc_next = br_tgt;
        else             pc_next = pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    logic unused_fields;
    assign unused_fields = ^{f.shamt, instr[ILEN-1:XLEN]};

    assign pc_o    = pc_q;
    assign instr_o = instr;
    assign alu_o   = alu_res;
endmodule

// File: rtl/mini_core_chk.sv
module mini_core_chk
    import mc_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] pc_o,
    input logic [ILEN-1:0] instr_o,
    input logic [XLEN-1:0] alu_o
);
    logic [5:0]      op;
    logic [XLEN-1:0] seq_pc, br_pc, jmp_pc;
    logic            redirect;

    assign op       = instr_o[31:26];
    assign seq_pc   = pc_o + XLEN'(4);
    assign br_pc    = seq_pc + {instr_o[XLEN-3:0], 2'b00};
    assign jmp_pc   = {instr_o[XLEN-3:0], 2'b00};
    assign redirect = (op == OP_BEQ) || (op == OP_BNE) || (op == OP_J);

    // R1
    a_r1_reset_pc: assert property (@(posedge clk) rst |=> pc_o == '0);

    // R2
    a_r2_pc_aligned: assert property (@(posedge clk) disable iff (rst)
        pc_o[1:0] == 2'b00);

    // R2
    a_r2_seq_advance: assert property (@(posedge clk) disable iff (rst)
        !redirect |=> pc_o == $past(seq_pc));

    // R3
    a_r3_slt_boolean: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RTYPE && instr_o[5:0] == FN_SLT) |-> alu_o[XLEN-1:1] == '0);

    // R7
    a_r7_beq_taken: assert property (@(posedge clk) disable iff (rst)
        (op == OP_BEQ && alu_o == '0) |=> pc_o == $past(br_pc));

    // R7
    a_r7_beq_fallthrough: assert property (@(posedge clk) disable iff (rst)
        (op == OP_BEQ && alu_o != '0) |=> pc_o == $past(seq_pc));

    // R8
    a_r8_bne_taken: assert property (@(posedge clk) disable iff (rst)
        (op == OP_BNE && alu_o != '0) |=> pc_o == $past(br_pc));

    // R9
    a_r9_jump_target: assert property (@(posedge clk) disable iff (rst)
        (op == OP_J) |=> pc_o == $past(jmp_pc));
endmodule

bind mini_core mini_core_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .pc_o    (pc_o),
    .instr_o (instr_o),
    .alu_o   (alu_o)
);

// File: tb/mini_core_tb_top.sv
`timescale 1ns/1ps
module mini_core_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        imem_we = 1'b0;
    logic [5:0]  imem_waddr = '0;
    logic [31:0] imem_wdata = '0;
    logic [7:0]  pc_o;
    logic [31:0] instr_o;
    logic [7:0]  alu_o;

    int vectors_applied = 0;
    int miscompares     = 0;

    always #4 clk = ~clk;

    mini_core dut_i (
        .clk        (clk),
        .rst        (rst),
        .imem_we    (imem_we),
        .imem_waddr (imem_waddr),
        .imem_wdata (imem_wdata),
        .pc_o       (pc_o),
        .instr_o    (instr_o),
        .alu_o      (alu_o)
    );

    // {instr[31:0], pc[7:0], alu[7:0], alu_checked, req[3:0]}
    localparam int NV = 29;
    localparam logic [52:0] VEC [NV] = '{
        {{6'h00,5'd1 ,5'd2 ,5'd10,5'd0,6'h20}, 8'd0  , 8'h03, 1'b1, 4'd3},  // R3 add
        {{6'h00,5'd2 ,5'd5 ,5'd11,5'd0,6'h22}, 8'd4  , 8'hFD, 1'b1, 4'd3},  // R3 sub
        {{6'h00,5'd7 ,5'd12,5'd12,5'd0,6'h24}, 8'd8  , 8'h04, 1'b1, 4'd3},  // R3 and
        {{6'h00,5'd8 ,5'd3 ,5'd13,5'd0,6'h25}, 8'd12 , 8'h0B, 1'b1, 4'd3},  // R3 or
        {{6'h00,5'd11,5'd1 ,5'd14,5'd0,6'h2A}, 8'd16 , 8'h01, 1'b1, 4'd3},  // R3 slt signed true
        {{6'h00,5'd1 ,5'd11,5'd15,5'd0,6'h2A}, 8'd20 , 8'h00, 1'b1, 4'd3},  // R3 slt false
        {{6'h00,5'd1 ,5'd2 ,5'd0 ,5'd0,6'h20}, 8'd24 , 8'h03, 1'b1, 4'd4},  // R4 write r0
        {{6'h00,5'd0 ,5'd0 ,5'd16,5'd0,6'h25}, 8'd28 , 8'h00, 1'b1, 4'd4},  // R4 r0 still 0
        {{6'h08,5'd0 ,5'd17,16'h0080}        , 8'd32 , 8'h80, 1'b1, 4'd5},  // R5 no sign ext
        {{6'h08,5'd17,5'd18,16'h12FF}        , 8'd36 , 8'h7F, 1'b1, 4'd5},  // R5 bits 15:8 ignored
        {{6'h2B,5'd3 ,5'd13,16'h0004}        , 8'd40 , 8'h07, 1'b1, 4'd6},  // R6 sw
        {{6'h2B,5'd30,5'd10,16'h0003}        , 8'd44 , 8'h21, 1'b1, 4'd6},  // R6 sw aliased
        {{6'h23,5'd2 ,5'd19,16'h0005}        , 8'd48 , 8'h07, 1'b1, 4'd6},  // R6 lw
        {{6'h23,5'd0 ,5'd20,16'h0021}        , 8'd52 , 8'h21, 1'b1, 4'd6},  // R6 lw aliased
        {{6'h00,5'd19,5'd20,5'd21,5'd0,6'h25}, 8'd56 , 8'h0B, 1'b1, 4'd6},  // R6 loaded values
        {{6'h04,5'd1 ,5'd2 ,16'h0003}        , 8'd60 , 8'hFF, 1'b1, 4'd7},  // R7 beq not taken
        {{6'h04,5'd10,5'd3 ,16'h0002}        , 8'd64 , 8'h00, 1'b1, 4'd7},  // R7 beq taken
        {{6'h05,5'd4 ,5'd4 ,16'h0005}        , 8'd76 , 8'h00, 1'b1, 4'd8},  // R8 bne not taken
        {{6'h05,5'd5 ,5'd6 ,16'h0001}        , 8'd80 , 8'hFF, 1'b1, 4'd8},  // R8 bne taken
        {{6'h3F,5'd1 ,5'd2 ,16'h0055}        , 8'd88 , 8'h00, 1'b0, 4'd10}, // R10 bad opcode
        {{6'h00,5'd1 ,5'd2 ,5'd2 ,5'd0,6'h3F}, 8'd92 , 8'h00, 1'b0, 4'd10}, // R10 bad funct
        {{6'h00,5'd2 ,5'd3 ,5'd22,5'd0,6'h20}, 8'd96 , 8'h05, 1'b1, 4'd10}, // R10 r2,r3 intact
        {{6'h02,26'd30}                      , 8'd100, 8'h00, 1'b0, 4'd9},  // R9 jump
        {{6'h08,5'd23,5'd23,16'h0001}        , 8'd120, 8'h18, 1'b1, 4'd5},
        {{6'h05,5'd23,5'd25,16'h00FE}        , 8'd124, 8'hFF, 1'b1, 4'd8},  // R8 backward
        {{6'h08,5'd23,5'd23,16'h0001}        , 8'd120, 8'h19, 1'b1, 4'd5},
        {{6'h05,5'd23,5'd25,16'h00FE}        , 8'd124, 8'h00, 1'b1, 4'd8},
        {{6'h02,26'h3FFFFE3}                 , 8'd128, 8'h00, 1'b0, 4'd9},  // R9 high bits ignored
        {{6'h00,5'd23,5'd0 ,5'd26,5'd0,6'h25}, 8'd140, 8'h19, 1'b1, 4'd3}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors_applied++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic imem_put(input logic [5:0] idx, input logic [31:0] w);
        @(negedge clk);
        imem_we    = 1'b1;
        imem_waddr = idx;
        imem_wdata = w;
        @(negedge clk);
        imem_we    = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "pc after reset", {24'h0, pc_o}, 32'h0);

        for (int w = 0; w < 64; w++) imem_put(6'(w), 32'h0);
        for (int i = 0; i < NV; i++) imem_put(VEC[i][20:15], VEC[i][52:21]);

        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            string rq;
            #1;
            rq = $sformatf("R%0d", VEC[i][3:0]);
            check(rq, "pc", {24'h0, pc_o}, {24'h0, VEC[i][20:13]});
            check("R2", "instr", instr_o, VEC[i][52:21]);
            if (VEC[i][4]) check(rq, "alu", {24'h0, alu_o}, {24'h0, VEC[i][12:5]});
            @(negedge clk);
        end

        // R1/R11: reload word 0 during reset; register 10 must be back to 10
        rst = 1'b1;
        imem_put(6'd0, {6'h00,5'd10,5'd0,5'd27,5'd0,6'h25});
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", "pc after re-reset", {24'h0, pc_o}, 32'h0);
        check("R11", "written word", instr_o, {6'h00,5'd10,5'd0,5'd27,5'd0,6'h25});
        check("R1", "r10 restored", {24'h0, alu_o}, 32'h0A);
        @(negedge clk);
        #1;
        check("R2", "pc sequential", {24'h0, pc_o}, 32'h4);
        check("R1", "r11 restored sub", {24'h0, alu_o}, 32'hFD);

        $display("== %0d vectors applied, %0d miscompares ==", vectors_applied, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors_applied, miscompares);
        $finish;
    end
endmodule